// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability with Per-Vector Masking

This block holds the registers of a PCI message-signalled interrupt capability and turns device interrupt requests into memory-write messages. Configuration software reads and writes the structure one dword at a time, with a byte-enable per lane. The device drives one request line per vector. A rising edge on an enabled, unmasked vector produces one message with an address and a data word on a valid/ready output. A rising edge on a masked vector only records a pending bit. That deferred message goes out when software later clears the mask bit while the capability is enabled.

The control logic is a two-state machine. `ST_IDLE` waits until at least one vector owes a message and the enable bit is set. It then takes the lowest-numbered owed vector, latches its address and data, and follows the transition `take` to `ST_SEND`. `ST_SEND` holds the message on the output until the sink accepts it, then follows `accept` back to `ST_IDLE`. With no owed vector, or with the enable bit clear, `ST_IDLE` stays where it is (`wait`). Without ready, `ST_SEND` also stays where it is (`stall`).

The `ADDR64` parameter selects between the 64-bit and the 32-bit address layout. `NUM_VEC` sets the number of vectors, from 1 to 32.

Top module: `msi_cap_ctrl`

## Requirements
- R1: After reset, dword 0 reads {control[15:0], next pointer = NEXT_PTR, 8'h05}. The control word has bit 8 = 1 (per-vector masking), bit 7 = ADDR64, bits 3:1 = the smallest n (at most 5) with 2^n >= NUM_VEC, and all other bits 0. The mask and pending registers read 0. With the defaults (8 vectors, 64-bit layout) dword 0 reads 32'h01860005.
- R2: Writes to byte 0 (ID), byte 1 (next pointer) and byte 3 (control bits 15:8) of dword 0 are ignored. In byte 2, only control bit 0 (enable) and bits 6:4 (enabled-message exponent, MME) take the written value. Bits 3:1 and bit 7 keep their values.
- R3: In the 64-bit layout, dword 1 is address[31:0], dword 2 is address[63:32], dword 3 is the data word, dword 4 is the mask and dword 5 is the pending register. In the 32-bit layout, dword 1 is the address, dword 2 is data, dword 3 is mask and dword 4 is pending. Only enabled byte lanes are written. The data word keeps bits 15:0, and bits 31:16 read 0. Mask bit i belongs to vector i. Pending ignores all writes.
- R4: Only a rising edge on a request line, seen while the enable bit is set, has any effect. A falling edge, or an edge while the block is disabled, sends nothing and leaves the pending bits unchanged.
- R5: A rising edge on a masked vector sets that vector's pending bit and sends no message.
- R6: A rising edge on an unmasked vector sends one message for it and clears its pending bit.
- R7: The message address is {address high, address low}, or the zero-extended low address in the 32-bit layout. The message data is {16'h0, data word} with its low MME bits replaced by the vector number.
- R8: While enabled, a mask write that clears a bit whose pending bit is set sends that vector's message and clears the pending bit. Setting a mask bit sends nothing. While disabled, clearing a mask bit sends nothing and keeps the pending bit.
- R9: Once msg_valid is high, it stays high with address and data unchanged until msg_ready is seen high at a clock edge.
- R10: When several vectors owe messages together, they are sent in ascending vector order.
- R11: No message starts while the enable bit is clear. A message owed when the block was disabled goes out after re-enabling, with the data format then in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 3 | Dword index within the capability |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the dword at cfg_dw (combinational) |
| irq_req | input | NUM_VEC | Per-vector interrupt request lines |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Sink accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Single-vector edges are driven with the vector masked, unmasked and with the block disabled. This separates pending capture from immediate sending and from the enable gate. Falling edges are checked to show that neither messages nor pending bits are produced. Words with several rising bits at once are used to check the ascending send order and the vector merge into the data bits. Random mask rewrites are applied on top of accumulated pending bits. These show that only the 1-to-0 mask transitions on pending vectors replay messages, and that pending bits set while disabled survive until the next enabled rising edge. A random ready signal holds messages across stalls so that hold stability is checked.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam logic [7:0] CAP_ID_MSI = 8'h05;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } msi_state_e;

    // Smallest n (capped at 5) with 2**n >= count.
    function automatic logic [2:0] mmc_of(input int count);
        logic [2:0] n;
        n = 3'd5;
        for (int k = 5; k >= 0; k--) begin
            if ((1 << k) >= count) n = 3'(k);
        end
        return n;
    endfunction

    // Merge the vector number into the low MME bits of the data word.
    function automatic logic [31:0] fmt_data(input logic [15:0] word,
                                             input logic [2:0]  mme,
                                             input logic [4:0]  vec);
        logic [15:0] low;
        low = (16'h0001 << mme) - 16'h0001;
        return {16'h0000, (word & ~low) | ({11'd0, vec} & low)};
    endfunction

    function automatic logic [31:0] merge_be(input logic [31:0] cur,
                                             input logic [31:0] wr,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[b*8 +: 8] = be[b] ? wr[b*8 +: 8] : cur[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_cap_pkg::*;
#(
    parameter int         NUM_VEC  = 8,
    parameter bit         ADDR64   = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         dw_idx,
    input  logic [3:0]         be,
    input  logic [31:0]        wdata,
    input  logic [NUM_VEC-1:0] pending,
    output logic [31:0]        rdata,
    output logic               msi_en,
    output logic [2:0]         mme,
    output logic [63:0]        base_addr,
    output logic [15:0]        data_word,
    output logic [NUM_VEC-1:0] mask,
    output logic [NUM_VEC-1:0] mask_clr
);

    localparam logic [2:0] DW_HDR  = 3'd0;
    localparam logic [2:0] DW_ALO  = 3'd1;
    localparam logic [2:0] DW_AHI  = 3'd2;
    localparam logic [2:0] DW_DATA = ADDR64 ? 3'd3 : 3'd2;
    localparam logic [2:0] DW_MASK = DW_DATA + 3'd1;
    localparam logic [2:0] DW_PEND = DW_MASK + 3'd1;
    localparam logic [2:0] MMC     = mmc_of(NUM_VEC);

    logic              en_q;
    logic [2:0]        mme_q;
    logic [31:0]       alo_q;
    logic [31:0]       ahi;
    logic [15:0]       data_q;
    logic [NUM_VEC-1:0] mask_q;
    logic [NUM_VEC-1:0] mask_nx;
    logic [15:0]       ctrl;
    logic [31:0]       mask_rd;
    logic [31:0]       pend_rd;

    logic hit_hdr, hit_alo, hit_data, hit_mask;
    assign hit_hdr  = wr_en && (dw_idx == DW_HDR);
    assign hit_alo  = wr_en && (dw_idx == DW_ALO);
    assign hit_data = wr_en && (dw_idx == DW_DATA);
    assign hit_mask = wr_en && (dw_idx == DW_MASK);

    // Control: only enable and MME take writes, through byte lane 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            mme_q <= 3'd0;
        end else if (hit_hdr && be[2]) begin
            en_q  <= wdata[16];
            mme_q <= wdata[22:20];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alo_q <= '0;
        end else if (hit_alo) begin
            alo_q <= merge_be(alo_q, wdata, be);
        end
    end

    generate
        if (ADDR64) begin : g_hi
            logic [31:0] ahi_q;
            logic        hit_ahi;
            assign hit_ahi = wr_en && (dw_idx == DW_AHI);
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ahi_q <= '0;
                end else if (hit_ahi) begin
                    ahi_q <= merge_be(ahi_q, wdata, be);
                end
            end
            assign ahi = ahi_q;
        end else begin : g_no_hi
            assign ahi = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (hit_data) begin
            if (be[0]) data_q[7:0]  <= wdata[7:0];
            if (be[1]) data_q[15:8] <= wdata[15:8];
        end
    end

    // Per-bit lane select for the mask.
    generate
        for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask
            assign mask_nx[i] = be[i / 8] ? wdata[i] : mask_q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (hit_mask) begin
            mask_q <= mask_nx;
        end
    end

    assign mask_clr = hit_mask ? (mask_q & ~mask_nx) : '0;

    assign ctrl = {7'd0, 1'b1, ADDR64, mme_q, MMC, en_q};

    always_comb begin
        mask_rd = '0;
        mask_rd[NUM_VEC-1:0] = mask_q;
        pend_rd = '0;
        pend_rd[NUM_VEC-1:0] = pending;
    end

    always_comb begin
        rdata = '0;
        if (dw_idx == DW_HDR)                  rdata = {ctrl, NEXT_PTR, CAP_ID_MSI};
        else if (dw_idx == DW_ALO)             rdata = alo_q;
        else if (ADDR64 && dw_idx == DW_AHI)   rdata = ahi;
        else if (dw_idx == DW_DATA)            rdata = {16'h0000, data_q};
        else if (dw_idx == DW_MASK)            rdata = mask_rd;
        else if (dw_idx == DW_PEND)            rdata = pend_rd;
    end

    assign msi_en    = en_q;
    assign mme       = mme_q;
    assign base_addr = {ahi, alo_q};
    assign data_word = data_q;
    assign mask      = mask_q;

endmodule

// File: rtl/msi_vec_tracker.sv
module msi_vec_tracker #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               msi_en,
    input  logic [NUM_VEC-1:0] mask,
    input  logic [NUM_VEC-1:0] mask_clr,
    input  logic [NUM_VEC-1:0] take_oh,
    output logic [NUM_VEC-1:0] rise,
    output logic [NUM_VEC-1:0] pending,
    output logic [NUM_VEC-1:0] owed
);

    logic [NUM_VEC-1:0] req_q;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] owed_q;
    logic [NUM_VEC-1:0] fire_now;
    logic [NUM_VEC-1:0] defer_now;
    logic [NUM_VEC-1:0] replay;

    assign rise      = irq_req & ~req_q & {NUM_VEC{msi_en}};
    assign fire_now  = rise & ~mask;
    assign defer_now = rise & mask;
    assign replay    = mask_clr & pend_q & {NUM_VEC{msi_en}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
            owed_q <= '0;
        end else begin
            req_q  <= irq_req;
            pend_q <= (pend_q & ~fire_now & ~replay) | defer_now;
            owed_q <= (owed_q & ~take_oh) | fire_now | replay;
        end
    end

    assign pending = pend_q;
    assign owed    = owed_q;

endmodule

// File: rtl/msi_low_pick.sv
module msi_low_pick #(
    parameter int NUM_VEC = 8,
    localparam int IDXW   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic [NUM_VEC-1:0] req,
    output logic               found,
    output logic [IDXW-1:0]    idx,
    output logic [NUM_VEC-1:0] onehot
);

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (req[i]) begin
                found  = 1'b1;
                idx    = IDXW'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
    import msi_cap_pkg::*;
#(
    parameter int         NUM_VEC  = 8,
    parameter bit         ADDR64   = 1'b1,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_dw,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    localparam int IDXW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic               msi_en;
    logic [2:0]         mme;
    logic [63:0]        base_addr;
    logic [15:0]        data_word;
    logic [NUM_VEC-1:0] mask;
    logic [NUM_VEC-1:0] mask_clr;
    logic [NUM_VEC-1:0] rise_vec;
    logic [NUM_VEC-1:0] pending;
    logic [NUM_VEC-1:0] owed;
    logic [NUM_VEC-1:0] pick_oh;
    logic [NUM_VEC-1:0] take_oh;
    logic               pick_found;
    logic [IDXW-1:0]    pick_idx;
    logic               take;

    msi_state_e  state_q, state_nx;
    logic [63:0] addr_q;
    logic [31:0] data_q;

    msi_cfg_regs #(
        .NUM_VEC  (NUM_VEC),
        .ADDR64   (ADDR64),
        .NEXT_PTR (NEXT_PTR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .dw_idx    (cfg_dw),
        .be        (cfg_be),
        .wdata     (cfg_wdata),
        .pending   (pending),
        .rdata     (cfg_rdata),
        .msi_en    (msi_en),
        .mme       (mme),
        .base_addr (base_addr),
        .data_word (data_word),
        .mask      (mask),
        .mask_clr  (mask_clr)
    );

    msi_vec_tracker #(
        .NUM_VEC (NUM_VEC)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .msi_en   (msi_en),
        .mask     (mask),
        .mask_clr (mask_clr),
        .take_oh  (take_oh),
        .rise     (rise_vec),
        .pending  (pending),
        .owed     (owed)
    );

    msi_low_pick #(
        .NUM_VEC (NUM_VEC)
    ) u_pick (
        .req    (owed),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state: take / wait from IDLE, accept / stall from SEND.
    always_comb begin
        state_nx = state_q;
        take     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found && msi_en) begin
                    take     = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                if (msg_ready) state_nx = ST_IDLE;
            end
        endcase
    end

    assign take_oh = pick_oh & {NUM_VEC{take}};

    // Message latch, loaded on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (take) begin
            addr_q <= base_addr;
            data_q <= fmt_data(data_word, mme, 5'(pick_idx));
        end
    end

    // Outputs.
    always_comb begin
        msg_valid = (state_q == ST_SEND);
        msg_addr  = addr_q;
        msg_data  = data_q;
    end

endmodule

// File: rtl/msi_cap_sva.sv
module msi_cap_sva #(
    parameter int NUM_VEC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               msi_en,
    input logic [NUM_VEC-1:0] rise,
    input logic [NUM_VEC-1:0] mask,
    input logic [NUM_VEC-1:0] pending
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    assert_masked_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & mask)) |=> ((pending & $past(rise & mask)) == $past(rise & mask)));

    assert_pending_only_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(rise & mask)) == '0));

    assert_unmasked_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rise & ~mask)) |=> ((pending & $past(rise & ~mask)) == '0));

    assert_start_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> $past(msi_en));

    assert_data_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:16] == 16'h0000));

endmodule

bind msi_cap_ctrl msi_cap_sva #(.NUM_VEC(NUM_VEC)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .msi_en    (msi_en),
    .rise      (rise_vec),
    .mask      (mask),
    .pending   (pending)
);

// File: tb/test_msi_cap_ctrl.sv
module test_msi_cap_ctrl;

    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_dw = '0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NV-1:0] irq_req = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int nchk = 0;
    int nfail = 0;

    // Bench model of the programmed state (64-bit layout).
    logic [NV-1:0] m_mask = '0;
    logic [NV-1:0] m_pend = '0;
    logic [NV-1:0] m_req  = '0;
    bit            m_en   = 1'b0;
    logic [2:0]    m_mme  = 3'd0;
    logic [63:0]   m_addr = '0;
    logic [15:0]   m_data = '0;

    always #4 clk = ~clk;

    msi_cap_ctrl #(.NUM_VEC(NV), .ADDR64(1'b1), .NEXT_PTR(8'h00)) i_msi_cap_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dw    (cfg_dw),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_req   (irq_req),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    function automatic logic [31:0] exp_data(input int v);
        logic [15:0] low;
        low = (16'h0001 << m_mme) - 16'h0001;
        return {16'h0000, (m_data & ~low) | (16'(v) & low)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] dw, output logic [31:0] d);
        @(negedge clk);
        cfg_dw = dw;
        #1;
        d = cfg_rdata;
    endtask

    // Collect messages for a window, compare with the ascending list in exp_set.
    task automatic drain_check(input logic [NV-1:0] exp_set, input string req);
        logic [63:0] ga [16];
        logic [31:0] gd [16];
        int          n = 0;
        int          k = 0;
        bit          pv = 1'b0, pr = 1'b0;
        logic [63:0] pa = '0;
        logic [31:0] pd = '0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            msg_ready = 1'($urandom_range(0, 1));
            #1;
            if (pv && !pr) begin
                chk("R9", "valid held", {63'd0, msg_valid}, 64'd1);
                chk("R9", "addr held", msg_addr, pa);
                chk("R9", "data held", {32'd0, msg_data}, {32'd0, pd});
            end
            if (msg_valid && msg_ready && n < 16) begin
                ga[n] = msg_addr; gd[n] = msg_data; n++;
            end
            pv = msg_valid; pr = msg_ready; pa = msg_addr; pd = msg_data;
        end
        @(negedge clk);
        msg_ready = 1'b0;
        chk(req, "message count", 64'(n), 64'($countones(exp_set)));
        for (int v = 0; v < NV; v++) begin
            if (exp_set[v] && k < n) begin
                chk("R7", "message address", ga[k], m_addr);
                chk((req == "R6") ? "R10" : req, "message data/order", {32'd0, gd[k]}, {32'd0, exp_data(v)});
                k++;
            end
        end
    endtask

    task automatic check_pending(input string req);
        logic [31:0] d;
        cfg_read(3'd5, d);
        chk(req, "pending", {32'd0, d}, {56'd0, m_pend});
    endtask

    task automatic raise(input logic [NV-1:0] w, input string req);
        logic [NV-1:0] rs, snd;
        @(negedge clk);
        irq_req = w;
        rs  = w & ~m_req & {NV{m_en}};
        snd = rs & ~m_mask;
        m_pend = (m_pend & ~snd) | (rs & m_mask);
        m_req = w;
        drain_check(snd, req);
        check_pending(req);
    endtask

    task automatic release_all();
        @(negedge clk);
        irq_req = '0;
        m_req = '0;
        drain_check('0, "R4");
        check_pending("R4");
    endtask

    task automatic write_mask(input logic [NV-1:0] nm, input string req);
        logic [NV-1:0] rp;
        rp = m_mask & ~nm & m_pend & {NV{m_en}};
        m_pend = m_pend & ~rp;
        m_mask = nm;
        cfg_write(3'd4, 4'hF, {24'd0, nm});
        drain_check(rp, req);
        check_pending(req);
    endtask

    task automatic set_ctrl(input bit en, input logic [2:0] mme);
        m_en = en; m_mme = mme;
        cfg_write(3'd0, 4'b0100, {9'd0, mme, 3'd0, en, 16'd0});
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset image
        cfg_read(3'd0, d); chk("R1", "header", {32'd0, d}, 64'h01860005);
        cfg_read(3'd4, d); chk("R1", "mask", {32'd0, d}, 64'd0);
        cfg_read(3'd5, d); chk("R1", "pending", {32'd0, d}, 64'd0);

        // R2 read-only fields of dword 0
        cfg_write(3'd0, 4'hF, 32'hFFFF_FFFF);
        cfg_read(3'd0, d); chk("R2", "header after ones", {32'd0, d}, 64'h01F70005);
        cfg_write(3'd0, 4'hF, 32'h0000_0000);
        cfg_read(3'd0, d); chk("R2", "header after zeros", {32'd0, d}, 64'h01860005);

        // R3 layout and byte lanes
        cfg_write(3'd1, 4'hF, 32'hFEE0_1000);
        cfg_write(3'd1, 4'b0001, 32'h1234_56AA);
        cfg_read(3'd1, d); chk("R3", "addr low lanes", {32'd0, d}, 64'hFEE010AA);
        cfg_write(3'd2, 4'hF, 32'h0000_0001);
        cfg_read(3'd2, d); chk("R3", "addr high", {32'd0, d}, 64'h1);
        cfg_write(3'd3, 4'hF, 32'hABCD_5A38);
        cfg_read(3'd3, d); chk("R3", "data word", {32'd0, d}, 64'h5A38);
        cfg_write(3'd5, 4'hF, 32'hFFFF_FFFF);
        cfg_read(3'd5, d); chk("R3", "pending ignores write", {32'd0, d}, 64'd0);
        m_addr = 64'h0000_0001_FEE0_10AA;
        m_data = 16'h5A38;

        // R4 edges while disabled are ignored
        raise(8'h03, "R4");
        release_all();

        set_ctrl(1'b1, 3'd3);
        // R5 masked vector records pending
        write_mask(8'h0F, "R5");
        raise(8'h04, "R5");
        release_all();
        // R8 unmask replays, setting a mask sends nothing
        write_mask(8'h0B, "R8");
        write_mask(8'hFF, "R8");
        raise(8'h02, "R5");
        release_all();
        set_ctrl(1'b0, 3'd3);
        write_mask(8'h00, "R8");
        set_ctrl(1'b1, 3'd3);
        check_pending("R8");
        // R6 unmasked edge sends and clears pending
        raise(8'h02, "R6");
        release_all();
        // R10 ascending order
        raise(8'hA5, "R10");
        release_all();

        // R11 edge and disable at the same edge: held until re-enable
        @(negedge clk);
        irq_req = 8'h10;
        cfg_wr = 1'b1; cfg_dw = 3'd0; cfg_be = 4'b0100; cfg_wdata = 32'h0;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_en = 1'b0; m_mme = 3'd0; m_req = 8'h10;
        drain_check('0, "R11");
        set_ctrl(1'b1, 3'd2);
        drain_check(8'h10, "R11");
        release_all();

        // Random mix
        for (int it = 0; it < 30; it++) begin
            if (it == 15) set_ctrl(1'b1, 3'(($urandom_range(0, 5))));
            write_mask(8'($urandom), "R8");
            raise(8'($urandom), "R6");
            release_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule